// File: doc/BRIEF.md
# Vertical-Blanking Packet Inserter

This block sits in the pixel pipeline of a progressive 525-line component video path. On one fixed line of the vertical blanking interval it replaces the luma samples with a 14-bit serial packet and holds both chroma channels at their mid-code blanking level. Every other line passes through untouched with one pixel clock of latency. The host composes the packet from a 6-bit header and an 8-bit payload. The block adds no coding of its own: it plays out exactly the bits it was given.

Packet updates are double-buffered. Writes land in staging storage. The live packet is replaced only when the payload register, the highest subaddress of the group, is written while insertion is enabled. The live packet can therefore never be caught half-written. The sample clock may run at the base rate or at twice that rate. In the double-rate mode every bit cell is twice as many samples long, so the bit duration in time does not change.

Top module: `vbi_pkt_inserter`

## Requirements
- R1: A line counter is set to 1 on the sample where `frameStart` and `lineStart` are both high, and advances on every other `lineStart`. The sample index is 0 on the `lineStart` sample. Every sample outside the data window passes through to the outputs unchanged, one clock later. The data window exists only on line `TARGET_LINE` (default 41).
- R2: The window begins at sample index `BIT_OFFSET` and lasts 14 bit cells of `SAMPLES_PER_BIT` samples each. Cell k carries bit 13-k of {header[5:0], payload[7:0]}, so the header goes out first and each field goes out MSB first.
- R3: Inside the window, a 1 bit drives Y to floor(1023*70/100) = 716 and a 0 bit drives Y to the blanking code `Y_BLANK` (default 0). No other luma value is produced inside the window.
- R4: Inside the window, Pb and Pr are both driven to the mid-scale blanking code 512.
- R5: When `rate2x` is high, each bit cell lasts 2*`SAMPLES_PER_BIT` samples and the window is twice as long.
- R6: A write to subaddress 0 stores regData[5:0] as the staged header. A write to subaddress 1 made while `enable` is high loads {staged header, regData} into the live packet. A write to subaddress 0, or a write to subaddress 1 while `enable` is low, leaves the live packet unchanged.
- R7: Writes to subaddresses 2 and 3 have no effect on either packet field.
- R8: While `enable` is low, all three channels pass through unchanged on every line, including the target line.
- R9: While `progMode` is low (another video format is selected), no insertion takes place.
- R10: After reset, all outputs are 0 and the live packet is all zeros, so the target line carries blanking-level cells until the first commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | High with lineStart on the first sample of line 1 |
| lineStart | input | 1 | High on the first sample of each line (horizontal reference) |
| progMode | input | 1 | 1 = progressive 525-line format selected |
| rate2x | input | 1 | 1 = twice-rate interpolated sample stream |
| enable | input | 1 | Insertion enable; also gates the commit of the live packet |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register subaddress (0 header, 1 payload) |
| regData | input | 8 | Register write data |
| yIn | input | 10 | Luma in |
| pbIn | input | 10 | Blue-difference chroma in |
| prIn | input | 10 | Red-difference chroma in |
| yOut | output | 10 | Luma out, registered |
| pbOut | output | 10 | Blue-difference chroma out, registered |
| prOut | output | 10 | Red-difference chroma out, registered |

## Verification
The assertions check on every clock several properties. Chroma sits at 512 whenever the control strobes insertion. Luma follows the strobed bit with one of exactly two levels. Insertion is never strobed while enable or the format flag is low, and in that case all channels pass through. The live packet changes only after a payload write made with enable set. Only the bench's scenarios can show the rest, because it depends on several frames of history. That covers the line and sample position of the window, the MSB-first order across header and payload, the doubled cells at twice the rate, a staged header surviving a write with enable low, and writes to unused subaddresses being ignored.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
  localparam int HDR_BITS = 6;
  localparam int PAY_BITS = 8;
  localparam int PKT_BITS = HDR_BITS + PAY_BITS;

  typedef struct packed {
    logic insert;
    logic bitVal;
  } insStrobe_t;
endpackage

// File: rtl/vbi_pkt_regs.sv
module vbi_pkt_regs #(
  parameter int ADDR_W   = 2,
  parameter int HDR_ADDR = 0,
  parameter int PAY_ADDR = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          enable,
  input  logic                          regWe,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [vbi_pkg::PAY_BITS-1:0]  regData,
  output logic [vbi_pkg::PKT_BITS-1:0]  livePkt
);
  import vbi_pkg::*;

  logic [HDR_BITS-1:0] hdrStage;
  logic hdrHit, payHit;

  assign hdrHit = regWe && (regAddr == ADDR_W'(HDR_ADDR));
  assign payHit = regWe && (regAddr == ADDR_W'(PAY_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrStage <= '0;
      livePkt  <= '0;
    end else begin
      if (hdrHit) hdrStage <= regData[HDR_BITS-1:0];
      // commit only from the top register of the group, and only while enabled
      if (payHit && enable) livePkt <= {hdrStage, regData};
    end
  end
endmodule

// File: rtl/vbi_ctrl.sv
module vbi_ctrl #(
  parameter int LINE_W          = 10,
  parameter int SAMPLE_W        = 12,
  parameter int TARGET_LINE     = 41,
  parameter int BIT_OFFSET      = 64,
  parameter int SAMPLES_PER_BIT = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         frameStart,
  input  logic                         lineStart,
  input  logic                         progMode,
  input  logic                         rate2x,
  input  logic                         enable,
  input  logic [vbi_pkg::PKT_BITS-1:0] livePkt,
  output vbi_pkg::insStrobe_t          strobe
);
  import vbi_pkg::*;

  localparam int WIN_1X = PKT_BITS * SAMPLES_PER_BIT;
  localparam int WIN_2X = 2 * WIN_1X;
  localparam int CELL_W = $clog2(2 * SAMPLES_PER_BIT);
  localparam int BIT_W  = $clog2(PKT_BITS + 1);
  localparam logic [SAMPLE_W:0]   OFF_X    = (SAMPLE_W+1)'(BIT_OFFSET);
  localparam logic [SAMPLE_W-1:0] SAMP_MAX = '1;
  localparam logic [LINE_W-1:0]   LINE_MAX = '1;

  logic [SAMPLE_W-1:0] sampleCnt, curSample;
  logic [LINE_W-1:0]   lineCnt, curLine;
  logic [CELL_W-1:0]   cellCnt, cellLastIdx;
  logic [BIT_W-1:0]    bitIdx;
  logic [SAMPLE_W:0]   winEnd;
  logic [PKT_BITS-1:0] pktShift;
  logic                inWin, onLine;

  always_comb begin
    if (lineStart)                curSample = '0;
    else if (sampleCnt == SAMP_MAX) curSample = SAMP_MAX;
    else                          curSample = sampleCnt + 1'b1;

    if (lineStart && frameStart)  curLine = LINE_W'(1);
    else if (lineStart && lineCnt != LINE_MAX) curLine = lineCnt + 1'b1;
    else                          curLine = lineCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCnt <= SAMP_MAX;
      lineCnt   <= '0;
    end else begin
      sampleCnt <= curSample;
      lineCnt   <= curLine;
    end
  end

  assign winEnd = OFF_X + (rate2x ? (SAMPLE_W+1)'(WIN_2X) : (SAMPLE_W+1)'(WIN_1X));
  assign onLine = (curLine == LINE_W'(TARGET_LINE));
  assign inWin  = enable && progMode && onLine &&
                  ({1'b0, curSample} >= OFF_X) && ({1'b0, curSample} < winEnd);

  assign cellLastIdx = rate2x ? CELL_W'(2 * SAMPLES_PER_BIT - 1)
                              : CELL_W'(SAMPLES_PER_BIT - 1);

  // cell/bit counters describe the current sample; cleared outside the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellCnt <= '0;
      bitIdx  <= '0;
    end else if (!inWin) begin
      cellCnt <= '0;
      bitIdx  <= '0;
    end else if (cellCnt == cellLastIdx) begin
      cellCnt <= '0;
      bitIdx  <= bitIdx + 1'b1;
    end else begin
      cellCnt <= cellCnt + 1'b1;
    end
  end

  assign pktShift      = livePkt << bitIdx;
  assign strobe.insert = inWin;
  assign strobe.bitVal = pktShift[PKT_BITS-1];
endmodule

// File: rtl/vbi_datapath.sv
module vbi_datapath #(
  parameter int PIX_W   = 10,
  parameter int Y_BLANK = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  vbi_pkg::insStrobe_t strobe,
  input  logic [PIX_W-1:0]    yIn,
  input  logic [PIX_W-1:0]    pbIn,
  input  logic [PIX_W-1:0]    prIn,
  output logic [PIX_W-1:0]    yOut,
  output logic [PIX_W-1:0]    pbOut,
  output logic [PIX_W-1:0]    prOut
);
  localparam int PEAK = (1 << PIX_W) - 1;
  localparam logic [PIX_W-1:0] Y_ONE   = PIX_W'((PEAK * 70) / 100);
  localparam logic [PIX_W-1:0] Y_ZERO  = PIX_W'(Y_BLANK);
  localparam logic [PIX_W-1:0] C_BLANK = PIX_W'(1 << (PIX_W - 1));
  localparam int N_CHROMA = 2;

  logic [PIX_W-1:0] chromaIn  [N_CHROMA];
  logic [PIX_W-1:0] chromaOut [N_CHROMA];

  assign chromaIn[0] = pbIn;
  assign chromaIn[1] = prIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              yOut <= '0;
    else if (strobe.insert) yOut <= strobe.bitVal ? Y_ONE : Y_ZERO;
    else                    yOut <= yIn;
  end

  for (genvar gi = 0; gi < N_CHROMA; gi++) begin : gChroma
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              chromaOut[gi] <= '0;
      else if (strobe.insert) chromaOut[gi] <= C_BLANK;
      else                    chromaOut[gi] <= chromaIn[gi];
    end
  end

  assign pbOut = chromaOut[0];
  assign prOut = chromaOut[1];
endmodule

// File: rtl/vbi_pkt_inserter.sv
module vbi_pkt_inserter #(
  parameter int PIX_W           = 10,
  parameter int ADDR_W          = 2,
  parameter int LINE_W          = 10,
  parameter int SAMPLE_W        = 12,
  parameter int TARGET_LINE     = 41,
  parameter int BIT_OFFSET      = 64,
  parameter int SAMPLES_PER_BIT = 12,
  parameter int Y_BLANK         = 0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         frameStart,
  input  logic                         lineStart,
  input  logic                         progMode,
  input  logic                         rate2x,
  input  logic                         enable,
  input  logic                         regWe,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [vbi_pkg::PAY_BITS-1:0] regData,
  input  logic [PIX_W-1:0]             yIn,
  input  logic [PIX_W-1:0]             pbIn,
  input  logic [PIX_W-1:0]             prIn,
  output logic [PIX_W-1:0]             yOut,
  output logic [PIX_W-1:0]             pbOut,
  output logic [PIX_W-1:0]             prOut
);
  import vbi_pkg::*;

  logic [PKT_BITS-1:0] livePkt;
  insStrobe_t          strobe;

  vbi_pkt_regs #(.ADDR_W(ADDR_W), .HDR_ADDR(0), .PAY_ADDR(1)) uRegs (
    .clk(clk), .rstN(rstN), .enable(enable), .regWe(regWe),
    .regAddr(regAddr), .regData(regData), .livePkt(livePkt)
  );

  vbi_ctrl #(
    .LINE_W(LINE_W), .SAMPLE_W(SAMPLE_W), .TARGET_LINE(TARGET_LINE),
    .BIT_OFFSET(BIT_OFFSET), .SAMPLES_PER_BIT(SAMPLES_PER_BIT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .progMode(progMode), .rate2x(rate2x), .enable(enable),
    .livePkt(livePkt), .strobe(strobe)
  );

  vbi_datapath #(.PIX_W(PIX_W), .Y_BLANK(Y_BLANK)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .yIn(yIn), .pbIn(pbIn), .prIn(prIn),
    .yOut(yOut), .pbOut(pbOut), .prOut(prOut)
  );
endmodule

// File: rtl/vbi_pkt_checker.sv
module vbi_pkt_checker #(
  parameter int PIX_W   = 10,
  parameter int ADDR_W  = 2,
  parameter int Y_BLANK = 0
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         enable,
  input logic                         progMode,
  input logic                         regWe,
  input logic [ADDR_W-1:0]            regAddr,
  input logic [PIX_W-1:0]             yIn,
  input logic [PIX_W-1:0]             pbIn,
  input logic [PIX_W-1:0]             prIn,
  input logic [PIX_W-1:0]             yOut,
  input logic [PIX_W-1:0]             pbOut,
  input logic [PIX_W-1:0]             prOut,
  input vbi_pkg::insStrobe_t          strobe,
  input logic [vbi_pkg::PKT_BITS-1:0] livePkt
);
  localparam logic [PIX_W-1:0] Y_ONE   = PIX_W'((((1 << PIX_W) - 1) * 70) / 100);
  localparam logic [PIX_W-1:0] Y_ZERO  = PIX_W'(Y_BLANK);
  localparam logic [PIX_W-1:0] C_BLANK = PIX_W'(1 << (PIX_W - 1));

  assert_chroma_blank_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.insert |=> (pbOut == C_BLANK) && (prOut == C_BLANK));

  assert_luma_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.insert |=> (yOut == ($past(strobe.bitVal) ? Y_ONE : Y_ZERO)));

  assert_no_insert_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.insert |-> (enable && progMode));

  assert_pass_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (yOut == $past(yIn)) && (pbOut == $past(pbIn)) && (prOut == $past(prIn)));

  assert_pass_format_R9: assert property (@(posedge clk) disable iff (!rstN)
    !progMode |=> (yOut == $past(yIn)) && (pbOut == $past(pbIn)) && (prOut == $past(prIn)));

  assert_commit_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(livePkt) |-> $past(regWe && (regAddr == ADDR_W'(1)) && enable));
endmodule

bind vbi_pkt_inserter vbi_pkt_checker #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .Y_BLANK(Y_BLANK)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .progMode(progMode),
  .regWe(regWe), .regAddr(regAddr), .yIn(yIn), .pbIn(pbIn), .prIn(prIn),
  .yOut(yOut), .pbOut(pbOut), .prOut(prOut), .strobe(strobe), .livePkt(livePkt)
);

// File: tb/tb_vbi_pkt_inserter.sv
`timescale 1ns/1ps
module tb_vbi_pkt_inserter;
  localparam int OFF      = 16;
  localparam int SPB      = 4;
  localparam int TGT      = 41;
  localparam int LINES    = 45;
  localparam int LINE_LEN = OFF + 14 * 2 * SPB + 12;

  logic clk = 0, rstN = 0;
  logic frameStart = 0, lineStart = 0, progMode = 1, rate2x = 0, enable = 0;
  logic regWe = 0;
  logic [1:0] regAddr = 0;
  logic [7:0] regData = 0;
  logic [9:0] yIn = 0, pbIn = 0, prIn = 0;
  logic [9:0] yOut, pbOut, prOut;

  int checks = 0, errors = 0;
  int genLine = 0, genSample = 0;
  string scen = "R10";

  // bench model state
  logic [5:0]  mHdr = 0;
  logic [13:0] mLive = 0;
  logic [9:0]  eY, ePb, ePr;
  string eTag;
  bit chk = 0;

  always #10 clk = ~clk;

  vbi_pkt_inserter #(.BIT_OFFSET(OFF), .SAMPLES_PER_BIT(SPB), .TARGET_LINE(TGT)) dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .progMode(progMode), .rate2x(rate2x), .enable(enable), .regWe(regWe),
    .regAddr(regAddr), .regData(regData), .yIn(yIn), .pbIn(pbIn), .prIn(prIn),
    .yOut(yOut), .pbOut(pbOut), .prOut(prOut)
  );

  function automatic bit inWindow(int ln, int s, bit en, bit pm, bit x2);
    int spb = x2 ? 2 * SPB : SPB;
    return en && pm && ln == TGT && s >= OFF && s < OFF + 14 * spb;
  endfunction

  function automatic logic [9:0] modelY(int s, bit x2, logic [13:0] pkt);
    int spb = x2 ? 2 * SPB : SPB;
    int k = (s - OFF) / spb;
    return pkt[13 - k] ? 10'd716 : 10'd0;
  endfunction

  always @(posedge clk) begin
    if (rstN) begin
      if (inWindow(genLine, genSample, enable, progMode, rate2x)) begin
        eY = modelY(genSample, rate2x, mLive); ePb = 10'd512; ePr = 10'd512;
        eTag = rate2x ? "R5" : "R2 R3 R4";
      end else begin
        eY = yIn; ePb = pbIn; ePr = prIn;
        eTag = (genLine == TGT && !enable) ? "R8" :
               (genLine == TGT && !progMode) ? "R9" : "R1";
      end
      chk = 1;
      if (regWe && regAddr == 2'd0) mHdr = regData[5:0];
      if (regWe && regAddr == 2'd1 && enable) mLive = {mHdr, regData};
    end else chk = 0;
  end

  always @(negedge clk) begin
    if (chk) begin
      checks++;
      if (yOut !== eY || pbOut !== ePb || prOut !== ePr) begin
        errors++;
        $display("FAIL %s [%s] line %0d sample %0d: got Y/Pb/Pr %0d/%0d/%0d exp %0d/%0d/%0d",
                 eTag, scen, genLine, genSample, yOut, pbOut, prOut, eY, ePb, ePr);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      genLine = 0; genSample = 0; lineStart = 0; frameStart = 0;
      yIn = 10'($urandom); pbIn = 10'($urandom); prIn = 10'($urandom);
      tick();
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d, bit en);
    enable = en; regWe = 1; regAddr = a; regData = d;
    genLine = 0; lineStart = 0; frameStart = 0;
    yIn = 10'($urandom); pbIn = 10'($urandom); prIn = 10'($urandom);
    tick();
    regWe = 0;
  endtask

  task automatic runFrame(bit en, bit pm, bit x2);
    enable = en; progMode = pm; rate2x = x2;
    for (int ln = 1; ln <= LINES; ln++) begin
      for (int s = 0; s < LINE_LEN; s++) begin
        genLine = ln; genSample = s;
        lineStart = (s == 0); frameStart = (s == 0 && ln == 1);
        yIn = 10'($urandom); pbIn = 10'($urandom); prIn = 10'($urandom);
        tick();
      end
    end
    lineStart = 0; frameStart = 0;
    idle(3);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (yOut !== 0 || pbOut !== 0 || prOut !== 0) begin
      errors++;
      $display("FAIL R10 reset outputs: got %0d/%0d/%0d exp 0/0/0", yOut, pbOut, prOut);
    end
    rstN = 1;
    idle(4);
    scen = "R10"; runFrame(1, 1, 0);                 // live packet still zero
    scen = "R6";
    wrReg(2'd0, 8'h2d, 0);
    wrReg(2'd1, 8'hb6, 1);                           // commit {2d,b6}
    runFrame(1, 1, 0);
    wrReg(2'd0, 8'h13, 1);                           // header staged only
    wrReg(2'd1, 8'h5a, 0);                           // payload write, enable low
    runFrame(1, 1, 0);
    scen = "R7";
    wrReg(2'd2, 8'hff, 1);
    wrReg(2'd3, 8'h00, 1);
    runFrame(1, 1, 0);
    scen = "R6";
    wrReg(2'd1, 8'hc3, 1);                           // commits staged 13 with c3
    runFrame(1, 1, 0);
    scen = "R5"; runFrame(1, 1, 1);
    scen = "R8"; runFrame(0, 1, 0);
    scen = "R9"; runFrame(1, 0, 1);
    scen = "random";
    for (int f = 0; f < 2; f++) begin
      wrReg(2'd0, 8'($urandom), 1);
      wrReg(2'd1, 8'($urandom), 1);
      runFrame(1, 1, 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule